// File: doc/BRIEF.md
# DMA Interrupt and Interrupt-Request Controller

This block holds the interrupt registers of a small system: a pending-status register with its mask, a DMA interrupt control register with per-channel completion flags, a DMA enable register, and one control word per DMA channel. The CPU reaches all of them through a 32-bit register port with read and write strobes and a word address. Completion pulses from the DMA channels and a bus-fault input feed the flags. Peripheral request pulses feed the status register. The block drives one CPU interrupt line.

The DMA register has a read-only summary bit. This bit is set when the global enable bit and any channel flag are both set, or when the bus-fault bit is set. Status bit 3 is raised only when this summary bit goes from 0 to 1. The block also decides whether a DMA channel may start. A start needs the start bit in the channel's control word and the channel's bit in the enable register. A start request that arrives while the channel is still busy is reported on a debug pulse.

Word addresses:
- 0: status
- 1: mask
- 2: DMA interrupt control
- 3: DMA enable
- 4+n: control word of channel n

Reads return data in the cycle after `cpu_rd`. Unmapped addresses read zero.

Top module: `dmairq_hub`

## Requirements
- R1: A write to status (word 0) keeps only the bits that are 1 in both the old value and the written value. An `irq_src` pulse sets the matching status bit. If a set and a clear of the same bit arrive in the same cycle, the set wins.
- R2: A write to mask (word 1) replaces the mask. The interrupt line follows the new mask one cycle later, with no further event needed.
- R3: A write to the DMA control register (word 2) loads only these fields: bits 0-5, bus-fault bit 15, channel enables 16-22 and global enable 23.
- R4: Writing 1 to a flag bit 24-30 clears it. Writing 0 to a flag bit leaves it unchanged.
- R5: Bit 31 of word 2 reads 1 exactly when (bit 23 is set and any of bits 24-30 is set) or bit 15 is set. Writes to bit 31 have no effect on it.
- R6: Status bit 3 is set in the same cycle that bit 31 of word 2 rises from 0. It is not set again while bit 31 stays high.
- R7: A write to word 4+n with bit 24 set starts channel n only when bit 4n+3 of the enable register (word 3) is set and the channel is idle. A start gives a one-cycle `chan_go[n]` pulse in the cycle after the write and makes the channel busy. A read of word 4+n returns the written word with bit 24 replaced by the busy state. `chan_done[n]` ends the busy state. The enable register reads back as written.
- R8: A start request to a busy channel gives a one-cycle `dbg_overlap` pulse in the cycle after the write, and no `chan_go` pulse.
- R9: `cpu_irq` is the OR of (status AND mask), registered, so it changes one cycle after status or mask changes.
- R10: A `chan_done[n]` pulse sets flag bit 24+n only if enable bit 16+n is set. Otherwise the pulse has no effect on word 2.
- R11: After reset, every register reads zero and `cpu_irq` is low.
- R12: A `bus_fault` pulse sets bit 15 of word 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Registered read data |
| irq_src | input | IRQ_W | Peripheral request pulses into status |
| chan_done | input | NCH | Per-channel DMA completion pulses |
| bus_fault | input | 1 | DMA bus-error pulse |
| chan_go | output | NCH | Per-channel start pulses |
| cpu_irq | output | 1 | CPU interrupt line |
| dbg_overlap | output | 1 | Start requested on a busy channel |

## Verification
The hardest state to reach from the ports is the summary bit staying high while status bit 3 has already been cleared by software. In that state a missing edge detector would set bit 3 again. The stimulus gets there by raising the summary bit through the bus-fault field, clearing status, and then reading status back. Later it lowers the summary bit and raises it again through a gated channel flag, to show that a new rising edge does set bit 3. The busy-channel case is reached by issuing a second start before the channel's completion pulse arrives.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned FLAG_LSB    = 24;
  localparam int unsigned FLAG_W      = 7;
  localparam int unsigned EN_LSB      = 16;
  localparam int unsigned GEN_BIT     = 23;
  localparam int unsigned BERR_BIT    = 15;
  localparam int unsigned SUM_BIT     = 31;
  localparam int unsigned START_BIT   = 24;
  localparam int unsigned DMA_IRQ_BIT = 3;
  localparam logic [DW-1:0] CTL_LOAD_MASK = 32'h00FF_803F;
  localparam logic [DW-1:0] FLAG_MASK     = 32'h7F00_0000;

  localparam int unsigned A_STATUS = 0;
  localparam int unsigned A_MASK   = 1;
  localparam int unsigned A_CTL    = 2;
  localparam int unsigned A_ENABLE = 3;
  localparam int unsigned A_CHAN   = 4;

  typedef struct packed {
    logic status;
    logic mask;
    logic ctl;
    logic enable;
  } wsel_t;
endpackage

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int unsigned IRQ_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_status,
  input  logic             wr_mask,
  input  logic [IRQ_W-1:0] wdata,
  input  logic [IRQ_W-1:0] set_vec,
  output logic [IRQ_W-1:0] status_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] status_q, status_n;
  logic [IRQ_W-1:0] mask_q, mask_n;
  logic             irq_q;

  always_comb begin
    status_n = wr_status ? ((status_q & wdata) | set_vec) : (status_q | set_vec);
    mask_n   = wr_mask ? wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      mask_q   <= mask_n;
      irq_q    <= |(status_q & mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  AST_STATUS_AND_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_status |=> ((status_q & ~$past(wdata) & ~$past(set_vec)) == '0)); // R1
endmodule

// File: rtl/dma_flag_unit.sv
module dma_flag_unit
  import dmairq_pkg::*;
#(
  parameter int unsigned NCH = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  input  logic [NCH-1:0] done,
  input  logic          bus_fault,
  output logic [DW-1:0] ctl_o,
  output logic          rise_o
);
  logic [DW-1:0]     ctl_q, ctl_n;
  logic [FLAG_W-1:0] hit;
  logic              sum_n;

  always_comb begin
    hit = '0;
    for (int n = 0; n < NCH; n++) begin
      hit[n] = done[n] & ctl_q[EN_LSB+n];
    end
  end

  always_comb begin
    if (wr_ctl) ctl_n = (wdata & CTL_LOAD_MASK) | (ctl_q & ~wdata & FLAG_MASK);
    else        ctl_n = ctl_q;
    ctl_n[FLAG_LSB +: FLAG_W] = ctl_n[FLAG_LSB +: FLAG_W] | hit;
    if (bus_fault) ctl_n[BERR_BIT] = 1'b1;
    sum_n = (ctl_n[GEN_BIT] & (|ctl_n[FLAG_LSB +: FLAG_W])) | ctl_n[BERR_BIT];
    ctl_n[SUM_BIT] = sum_n;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_n;
  end

  assign ctl_o  = ctl_q;
  assign rise_o = sum_n & ~ctl_q[SUM_BIT];

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> ((ctl_q[FLAG_LSB +: FLAG_W] & $past(wdata[FLAG_LSB +: FLAG_W]) & ~$past(hit)) == '0)); // R4
endmodule

// File: rtl/dma_chan_gate.sv
module dma_chan_gate
  import dmairq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          en_bit,
  input  logic          done,
  output logic [DW-1:0] word_o,
  output logic          go_o,
  output logic          clash_o
);
  logic [DW-1:0] word_q;
  logic          busy_q, go_q, clash_q;
  logic          req, launch;

  assign req    = wr & wdata[START_BIT];
  assign launch = req & en_bit & ~busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      busy_q  <= 1'b0;
      go_q    <= 1'b0;
      clash_q <= 1'b0;
    end else begin
      if (wr) word_q <= wdata;
      go_q    <= launch;
      clash_q <= req & busy_q;
      if (launch)    busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
    end
  end

  always_comb begin
    word_o            = word_q;
    word_o[START_BIT] = busy_q;
  end
  assign go_o    = go_q;
  assign clash_o = clash_q;

  AST_GO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    go_q |-> $past(en_bit & wr & wdata[START_BIT])); // R7
  AST_CLASH_BLOCKS_GO: assert property (@(posedge clk) disable iff (rst)
    clash_q |-> !go_q); // R8
endmodule

// File: rtl/dmairq_hub.sv
module dmairq_hub
  import dmairq_pkg::*;
#(
  parameter int unsigned NCH   = 7,
  parameter int unsigned IRQ_W = 11,
  parameter int unsigned AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  input  logic [IRQ_W-1:0] irq_src,
  input  logic [NCH-1:0]   chan_done,
  input  logic             bus_fault,
  output logic [NCH-1:0]   chan_go,
  output logic             cpu_irq,
  output logic             dbg_overlap
);
  localparam int unsigned LAST_ADDR = A_CHAN + NCH - 1;

  wsel_t            wsel;
  logic [DW-1:0]    en_q;
  logic [DW-1:0]    ctl;
  logic             rise;
  logic [IRQ_W-1:0] status, mask, set_vec;
  logic [DW-1:0]    chan_word [NCH];
  logic [NCH-1:0]   clash;
  logic [NCH-1:0]   chan_wr;
  logic [DW-1:0]    rd_mux, rdata_q;

  always_comb begin
    wsel.status = cpu_wr && (cpu_addr == AW'(A_STATUS));
    wsel.mask   = cpu_wr && (cpu_addr == AW'(A_MASK));
    wsel.ctl    = cpu_wr && (cpu_addr == AW'(A_CTL));
    wsel.enable = cpu_wr && (cpu_addr == AW'(A_ENABLE));
    for (int n = 0; n < NCH; n++) begin
      chan_wr[n] = cpu_wr && (cpu_addr == AW'(A_CHAN + n));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              en_q <= '0;
    else if (wsel.enable) en_q <= cpu_wdata;
  end

  dma_flag_unit #(.NCH(NCH)) i_flags (
    .clk(clk), .rst(rst), .wr_ctl(wsel.ctl), .wdata(cpu_wdata),
    .done(chan_done), .bus_fault(bus_fault), .ctl_o(ctl), .rise_o(rise)
  );

  always_comb begin
    set_vec = irq_src;
    set_vec[DMA_IRQ_BIT] = irq_src[DMA_IRQ_BIT] | rise;
  end

  irq_status_unit #(.IRQ_W(IRQ_W)) i_status (
    .clk(clk), .rst(rst), .wr_status(wsel.status), .wr_mask(wsel.mask),
    .wdata(cpu_wdata[IRQ_W-1:0]), .set_vec(set_vec),
    .status_o(status), .mask_o(mask), .irq_o(cpu_irq)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_chan_gate i_gate (
      .clk(clk), .rst(rst), .wr(chan_wr[g]), .wdata(cpu_wdata),
      .en_bit(en_q[4*g+3]), .done(chan_done[g]),
      .word_o(chan_word[g]), .go_o(chan_go[g]), .clash_o(clash[g])
    );
  end

  assign dbg_overlap = |clash;

  always_comb begin
    rd_mux = '0;
    if (cpu_addr == AW'(A_STATUS))      rd_mux = DW'(status);
    else if (cpu_addr == AW'(A_MASK))   rd_mux = DW'(mask);
    else if (cpu_addr == AW'(A_CTL))    rd_mux = ctl;
    else if (cpu_addr == AW'(A_ENABLE)) rd_mux = en_q;
    else if (cpu_addr <= AW'(LAST_ADDR)) begin
      for (int n = 0; n < NCH; n++) begin
        if (cpu_addr == AW'(A_CHAN + n)) rd_mux = chan_word[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (cpu_rd) rdata_q <= rd_mux;
  end
  assign cpu_rdata = rdata_q;

  AST_DMA_EDGE_SETS_BIT3: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl[SUM_BIT]) |-> status[DMA_IRQ_BIT]); // R6
endmodule

// File: tb/test_dmairq_hub.sv
module test_dmairq_hub;
  localparam int unsigned NCH = 7, IRQ_W = 11, AW = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic             cpu_wr, cpu_rd;
  logic [AW-1:0]    cpu_addr;
  logic [31:0]      cpu_wdata, cpu_rdata;
  logic [IRQ_W-1:0] irq_src;
  logic [NCH-1:0]   chan_done, chan_go;
  logic             bus_fault, cpu_irq, dbg_overlap;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dmairq_hub #(.NCH(NCH), .IRQ_W(IRQ_W), .AW(AW)) i_dmairq_hub (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_src(irq_src),
    .chan_done(chan_done), .bus_fault(bus_fault), .chan_go(chan_go),
    .cpu_irq(cpu_irq), .dbg_overlap(dbg_overlap)
  );

  typedef struct packed {
    logic        rd;
    logic [3:0]  a;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'd1, 32'h0000_07FF},
    '{1'b1, 4'd1, 32'h0000_07FF},  // R2 mask replaced
    '{1'b0, 4'd2, 32'hFFFF_FFFF},
    '{1'b1, 4'd2, 32'h80FF_803F},  // R3 load mask, R5 summary via bit 15
    '{1'b1, 4'd0, 32'h0000_0008},  // R6 bit 3 on rise
    '{1'b0, 4'd0, 32'h0000_0000},
    '{1'b1, 4'd0, 32'h0000_0000},  // R6 not raised again while high
    '{1'b0, 4'd2, 32'h0000_0000},
    '{1'b1, 4'd2, 32'h0000_0000},  // R5 summary drops
    '{1'b0, 4'd3, 32'h1234_5678},
    '{1'b1, 4'd3, 32'h1234_5678}   // R7 enable register readback
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic pulse_done(input logic [NCH-1:0] v);
    @(negedge clk);
    chan_done = v;
    @(negedge clk);
    chan_done = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    irq_src = '0; chan_done = '0; bus_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    for (int a = 0; a < 11; a++) begin
      do_rd(4'(a), r);
      check(r, 32'h0, "R11 register zero after reset");
    end
    check({31'h0, cpu_irq}, 32'h0, "R11 irq low after reset");

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rd) begin
        do_rd(TBL[i].a, r);
        check(r, TBL[i].d, $sformatf("table entry %0d", i));
      end else begin
        do_wr(TBL[i].a, TBL[i].d);
      end
    end

    // R9 latency of irq line, R1 set by source
    @(negedge clk); irq_src = 11'h022;
    @(negedge clk); irq_src = '0;
    check({31'h0, cpu_irq}, 32'h0, "R9 irq not yet high");
    @(negedge clk);
    check({31'h0, cpu_irq}, 32'h1, "R9 irq high one cycle later");
    do_rd(4'd0, r);
    check(r, 32'h22, "R1 source sets status");
    do_wr(4'd0, 32'hFFFF_FFFD);
    do_rd(4'd0, r);
    check(r, 32'h20, "R1 and-write clears only zero bits");

    // R2 mask change re-evaluates irq
    do_wr(4'd1, 32'h0);
    @(negedge clk);
    check({31'h0, cpu_irq}, 32'h0, "R2 irq drops with mask cleared");
    do_wr(4'd1, 32'h20);
    @(negedge clk);
    check({31'h0, cpu_irq}, 32'h1, "R2 irq rises with new mask");
    do_wr(4'd0, 32'h0);

    // R10 completion gated by per-channel enable
    pulse_done(7'b0000100);
    do_rd(4'd2, r);
    check(r, 32'h0, "R10 done ignored without enable");
    do_wr(4'd2, 32'h0004_0000);
    pulse_done(7'b0000100);
    do_rd(4'd2, r);
    check(r, 32'h0404_0000, "R10 flag set, R5 summary low without global");
    do_wr(4'd2, 32'h0084_0000);
    do_rd(4'd2, r);
    check(r, 32'h8484_0000, "R4 zero keeps flag, R5 summary high");
    do_rd(4'd0, r);
    check(r, 32'h8, "R6 new rise sets bit 3");
    do_wr(4'd2, 32'h8484_0000);
    do_rd(4'd2, r);
    check(r, 32'h0084_0000, "R4 one clears flag, R5 bit 31 not writable");
    do_wr(4'd0, 32'h0);

    // R12 bus fault
    @(negedge clk); bus_fault = 1'b1;
    @(negedge clk); bus_fault = 1'b0;
    do_rd(4'd2, r);
    check(r, 32'h8084_8000, "R12 bus fault sets bit 15");
    do_rd(4'd0, r);
    check(r, 32'h8, "R6 bus fault rise sets bit 3");
    do_wr(4'd2, 32'h0084_0000);
    do_wr(4'd0, 32'h0);

    // R7 channel start, R8 overlap
    do_wr(4'd3, 32'h0000_0080);
    do_wr(4'd5, 32'h0100_0000);
    check({25'h0, chan_go}, 32'h2, "R7 channel 1 go pulse");
    check({31'h0, dbg_overlap}, 32'h0, "R8 no overlap on first start");
    @(negedge clk);
    check({25'h0, chan_go}, 32'h0, "R7 go is one cycle");
    do_rd(4'd5, r);
    check(r, 32'h0100_0000, "R7 busy reads as bit 24");
    do_wr(4'd5, 32'h0100_0000);
    check({31'h0, dbg_overlap}, 32'h1, "R8 overlap flagged");
    check({25'h0, chan_go}, 32'h0, "R8 no go while busy");
    pulse_done(7'b0000010);
    do_rd(4'd5, r);
    check(r, 32'h0, "R7 done clears busy");
    do_wr(4'd6, 32'h0100_0000);
    check({25'h0, chan_go}, 32'h0, "R7 no go without enable bit 11");
    do_rd(4'd6, r);
    check(r, 32'h0, "R7 channel 2 stays idle");

    // R11 reset mid-run
    do_wr(4'd1, 32'h7FF);
    do_wr(4'd0, 32'h0);
    @(negedge clk); irq_src = 11'h001;
    @(negedge clk); irq_src = '0;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check({31'h0, cpu_irq}, 32'h0, "R11 irq low after reset");
    for (int a = 0; a < 4; a++) begin
      do_rd(4'(a), r);
      check(r, 32'h0, "R11 registers cleared by reset");
    end

    finished = 1;
    finish_run();
  end
endmodule